// File: doc/BRIEF.md
# Prioritised Interrupt Distributor

This block gathers pending requests from up to `NSRC` external interrupt sources and delivers them to `NCTX` processor contexts. Each source carries a small programmable priority. Each context has its own enable bit per source, its own priority threshold and one claim/complete register. A context raises its interrupt line whenever some source is pending, enabled for it, not already claimed, and has a priority strictly above its threshold.

Software handles an interrupt in two steps. First it reads the context's claim register. The read returns the identifier of the winning source and marks that source as taken, so that no context receives it again. When the handler has finished, software writes the same identifier back to the claim register. The block then clears the taken mark and pulses a per-source completion line, which tells the upstream gateway that it may forward a new request. Identifier 0 means "no source": it is never pending, never enabled and never returned, except as the empty answer of a claim read.

The register port carries one access at a time and is driven by a two-state machine. In `ST_IDLE` a request is accepted and acted on at the next clock edge, and the machine moves to `ST_ACK`. In `ST_ACK` the port asserts `bus_ack_o` for exactly one cycle with the read data, ignores any request, and returns unconditionally to `ST_IDLE`.

Top module: `irq_router`

## Requirements
- R1: After reset all priorities, enables and thresholds read 0, every `irq_o` bit is 0, nothing is marked claimed, and a claim read returns 0.
- R2: The priority of source s is at byte address 4*s and is `PRIO_W` (3) bits wide, with the upper bits reading 0. The entry for source 0 always reads 0 and ignores writes.
- R3: The enable word of context c is at 0x2000 + 0x80*c. Source n is bit (n mod 32) of word n/32 (byte offset 4*(n/32)). Bit 0 of word 0 always reads 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c. A source is eligible for c only if its priority is strictly greater than the threshold, so priority 0 never interrupts.
- R5: Among eligible sources, the claim returns the one with the highest priority. When priorities are equal, the lowest identifier wins.
- R6: A read of the claim register at 0x200004 + 0x1000*c returns the winning identifier and marks that source claimed, so no context is given it again until it is completed. The read returns 0 when no source is eligible.
- R7: A write of identifier n to a claim register clears the claim of n and drives `src_done_o[n]` high during the acknowledge cycle only. This applies when 1 <= n <= NSRC and n is enabled for that context.
- R8: A completion write naming a source that is not enabled for that context, or an identifier out of range, has no effect. No done pulse is produced and the claim stays in place.
- R9: `irq_o[c]` is registered. It is high in a cycle exactly when c had an eligible source in the previous cycle.
- R10: Reads from unmapped addresses return 0 and writes to them change no state. This covers nonexistent contexts and enable words past the last source.
- R11: A request seen in `ST_IDLE` is acknowledged one cycle later, with `bus_ack_o` high for one cycle. A request presented during `ST_ACK` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Access request, taken in ST_IDLE |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (26) | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Access done, high for one cycle |
| bus_rdata_o | output | 32 | Read data, valid with bus_ack_o |
| src_pend_i | input | NSRC (31) | Pending bits from the gateways, bit n is source n |
| src_done_o | output | NSRC (31) | Completion pulse to the gateway of source n |
| irq_o | output | NCTX (2) | Interrupt request per context |

## Verification
The hardest situation to reach is a completion write that must be refused. The source has to be claimed through one context and then disabled for the context that completes it, or it has to be enabled only for some other context. A later claim read must then show that the claim was really kept. Directed sequences build these cross-context cases, including ties in priority and a priority equal to the threshold. A long random mix of priority, enable, threshold, pending, claim and completion traffic, with completions biased toward sources that are currently claimed, is checked against a bench model of the arbitration rule.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_state_e;

    // address map pieces that the decoder relies on
    localparam logic [31:0] ENABLE_BASE   = 32'h0000_2000;
    localparam logic [31:0] ENABLE_STRIDE = 32'h0000_0080;
    localparam logic [31:0] CTX_BASE      = 32'h0020_0000;
    localparam logic [31:0] CTX_STRIDE    = 32'h0000_1000;
    localparam logic [9:0]  THR_WORD      = 10'd0;
    localparam logic [9:0]  CLAIM_WORD    = 10'd1;

endpackage

// File: rtl/irq_router_arb.sv
module irq_router_arb #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic [NSRC:0][PRIO_W-1:0] prio_i,
    input  logic [NSRC:0]             en_i,
    input  logic [PRIO_W-1:0]         thr_i,
    input  logic [NSRC:0]             pend_i,
    input  logic [NSRC:0]             claimed_i,
    output logic [ID_W-1:0]           best_id_o,
    output logic                      any_o
);

    logic [NSRC:0] elig;

    generate
        for (genvar s = 0; s <= NSRC; s++) begin : g_elig
            if (s == 0) begin : g_none
                assign elig[s] = 1'b0;
            end else begin : g_src
                assign elig[s] = pend_i[s] & en_i[s] & ~claimed_i[s] & (prio_i[s] > thr_i);
            end
        end
    endgenerate

    logic [PRIO_W-1:0] best_p;

    // ascending scan with strict compare keeps the lowest id on ties
    always_comb begin
        best_p    = '0;
        best_id_o = '0;
        for (int s = 1; s <= NSRC; s++) begin
            if (elig[s] && (prio_i[s] > best_p)) begin
                best_p    = prio_i[s];
                best_id_o = ID_W'(s);
            end
        end
    end

    assign any_o = |elig;

endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 26,
    parameter int ID_W   = 5,
    parameter int CTX_IW = 1
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          bus_req_i,
    input  logic                          bus_we_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic [31:0]                   bus_wdata_i,
    input  logic [NCTX-1:0][ID_W-1:0]     best_id_i,
    output logic                          bus_ack_o,
    output logic [31:0]                   bus_rdata_o,
    output logic [NSRC:0][PRIO_W-1:0]     prio_o,
    output logic [NCTX-1:0][NSRC:0]       en_o,
    output logic [NCTX-1:0][PRIO_W-1:0]   thr_o,
    output logic [NSRC:0]                 claimed_o,
    output logic [NSRC:0]                 done_o
);

    localparam int NWORDS = (NSRC + 32) / 32;

    bus_state_e state_q, state_d;

    logic [NSRC:0][PRIO_W-1:0]   prio_q;
    logic [NCTX-1:0][NSRC:0]     en_q;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;
    logic [NSRC:0]               claimed_q;
    logic [NSRC:0]               done_q;
    logic [31:0]                 rdata_q;

    logic [31:0]       addr32, en_off, ctx_off;
    logic [ID_W-1:0]   prio_idx, cpl_id;
    logic [CTX_IW-1:0] en_ctx, reg_ctx;
    logic [4:0]        en_word;
    logic              hit_prio, hit_en, in_ctx, hit_thr, hit_claim, cpl_ok, accept;
    logic [NSRC:0]     en_mask, en_val;
    logic [31:0]       en_rd, rd_val;

    assign addr32 = 32'(bus_addr_i);

    // address decode
    always_comb begin
        en_off    = addr32 - ENABLE_BASE;
        ctx_off   = addr32 - CTX_BASE;
        prio_idx  = ID_W'(addr32 >> 2);
        en_ctx    = CTX_IW'(en_off >> 7);
        en_word   = en_off[6:2];
        reg_ctx   = CTX_IW'(ctx_off >> 12);
        hit_prio  = addr32 < 32'(4 * (NSRC + 1));
        hit_en    = (addr32 >= ENABLE_BASE)
                 && (addr32 < (ENABLE_BASE + 32'(NCTX) * ENABLE_STRIDE))
                 && ({27'd0, en_word} < 32'(NWORDS));
        in_ctx    = (addr32 >= CTX_BASE)
                 && (addr32 < (CTX_BASE + 32'(NCTX) * CTX_STRIDE));
        hit_thr   = in_ctx && (ctx_off[11:2] == THR_WORD);
        hit_claim = in_ctx && (ctx_off[11:2] == CLAIM_WORD);
    end

    // enable word slicing: which ids live in the addressed word
    always_comb begin
        en_mask = '0;
        en_val  = '0;
        en_rd   = '0;
        for (int s = 1; s <= NSRC; s++) begin
            if (5'(s >> 5) == en_word) begin
                en_mask[s]    = 1'b1;
                en_val[s]     = bus_wdata_i[s % 32];
                en_rd[s % 32] = en_q[en_ctx][s];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (hit_prio) begin
            rd_val = 32'(prio_q[prio_idx]);
        end else if (hit_en) begin
            rd_val = en_rd;
        end else if (hit_thr) begin
            rd_val = 32'(thr_q[reg_ctx]);
        end else if (hit_claim) begin
            rd_val = 32'(best_id_i[reg_ctx]);
        end
    end

    assign cpl_id = ID_W'(bus_wdata_i);
    assign cpl_ok = (bus_wdata_i >= 32'd1) && (bus_wdata_i <= 32'(NSRC))
                 && en_q[reg_ctx][cpl_id];
    assign accept = (state_q == ST_IDLE) && bus_req_i;

    // bus state machine: state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_req_i) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // bus state machine: outputs
    always_comb begin
        bus_ack_o   = (state_q == ST_ACK);
        bus_rdata_o = rdata_q;
    end

    // register storage and claim bookkeeping
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prio_q    <= '0;
            en_q      <= '0;
            thr_q     <= '0;
            claimed_q <= '0;
            done_q    <= '0;
            rdata_q   <= '0;
        end else begin
            done_q <= '0;
            if (accept) begin
                rdata_q <= bus_we_i ? 32'd0 : rd_val;
                if (bus_we_i) begin
                    if (hit_prio && (prio_idx != '0)) begin
                        prio_q[prio_idx] <= bus_wdata_i[PRIO_W-1:0];
                    end
                    if (hit_en) begin
                        en_q[en_ctx] <= (en_q[en_ctx] & ~en_mask) | (en_val & en_mask);
                    end
                    if (hit_thr) begin
                        thr_q[reg_ctx] <= bus_wdata_i[PRIO_W-1:0];
                    end
                    if (hit_claim && cpl_ok) begin
                        claimed_q[cpl_id] <= 1'b0;
                        done_q[cpl_id]    <= 1'b1;
                    end
                end else if (hit_claim && (best_id_i[reg_ctx] != '0)) begin
                    claimed_q[best_id_i[reg_ctx]] <= 1'b1;
                end
            end
        end
    end

    assign prio_o    = prio_q;
    assign en_o      = en_q;
    assign thr_o     = thr_q;
    assign claimed_o = claimed_q;
    assign done_o    = done_q;

endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 26
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic              bus_ack_o,
    output logic [31:0]       bus_rdata_o,
    input  logic [NSRC:1]     src_pend_i,
    output logic [NSRC:1]     src_done_o,
    output logic [NCTX-1:0]   irq_o
);

    localparam int ID_W   = $clog2(NSRC + 1);
    localparam int CTX_IW = (NCTX > 1) ? $clog2(NCTX) : 1;

    logic [NSRC:0][PRIO_W-1:0]   prio_w;
    logic [NCTX-1:0][NSRC:0]     en_w;
    logic [NCTX-1:0][PRIO_W-1:0] thr_w;
    logic [NSRC:0]               claimed_w;
    logic [NSRC:0]               done_w;
    logic [NSRC:0]               pend_w;
    logic [NCTX-1:0][ID_W-1:0]   best_id_w;
    logic [NCTX-1:0]             any_w;
    logic [NCTX-1:0]             irq_q;

    assign pend_w = {src_pend_i, 1'b0};

    irq_router_regs #(
        .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W),
        .ADDR_W(ADDR_W), .ID_W(ID_W), .CTX_IW(CTX_IW)
    ) regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bus_req_i  (bus_req_i),
        .bus_we_i   (bus_we_i),
        .bus_addr_i (bus_addr_i),
        .bus_wdata_i(bus_wdata_i),
        .best_id_i  (best_id_w),
        .bus_ack_o  (bus_ack_o),
        .bus_rdata_o(bus_rdata_o),
        .prio_o     (prio_w),
        .en_o       (en_w),
        .thr_o      (thr_w),
        .claimed_o  (claimed_w),
        .done_o     (done_w)
    );

    generate
        for (genvar c = 0; c < NCTX; c++) begin : g_ctx
            irq_router_arb #(
                .NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
            ) arb_i (
                .prio_i   (prio_w),
                .en_i     (en_w[c]),
                .thr_i    (thr_w[c]),
                .pend_i   (pend_w),
                .claimed_i(claimed_w),
                .best_id_o(best_id_w[c]),
                .any_o    (any_w[c])
            );
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q <= '0;
        end else begin
            irq_q <= any_w;
        end
    end

    assign irq_o      = irq_q;
    assign src_done_o = done_w[NSRC:1];

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NSRC = 31,
    parameter int NCTX = 2
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            bus_req_i,
    input logic            bus_we_i,
    input logic            bus_ack_o,
    input logic [NSRC:1]   src_pend_i,
    input logic [NSRC:1]   src_done_o,
    input logic [NCTX-1:0] irq_o
);

    p_ack_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_ack_o |=> !bus_ack_o);

    p_req_acked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_i && !bus_ack_o) |=> bus_ack_o);

    p_done_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(src_done_o));

    p_done_from_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_done_o != '0) |-> $past(bus_req_i && bus_we_i && !bus_ack_o));

    p_done_with_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_done_o != '0) |-> bus_ack_o);

    p_irq_needs_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o != '0) |-> ($past(src_pend_i) != '0));

endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NCTX(NCTX)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_req_i (bus_req_i),
    .bus_we_i  (bus_we_i),
    .bus_ack_o (bus_ack_o),
    .src_pend_i(src_pend_i),
    .src_done_o(src_done_o),
    .irq_o     (irq_o)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;

    localparam int NSRC   = 31;
    localparam int NCTX   = 2;
    localparam int ADDR_W = 26;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic              ack;
    logic [31:0]       rdata;
    logic [NSRC:1]     pend = '0;
    logic [NSRC:1]     done;
    logic [NCTX-1:0]   irq;

    always #10 clk = ~clk;

    irq_router #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_ack_o(ack),
        .bus_rdata_o(rdata), .src_pend_i(pend), .src_done_o(done), .irq_o(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;

    int m_prio[32];
    bit m_en[NCTX][32];
    int m_thr[NCTX];
    bit m_claimed[32];

    logic [31:0]   last_rd;
    logic [NSRC:1] last_done;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] prio_a(input int s);
        return 32'(4 * s);
    endfunction
    function automatic logic [31:0] en_a(input int c);
        return 32'h2000 + 32'(c) * 32'h80;
    endfunction
    function automatic logic [31:0] thr_a(input int c);
        return 32'h20_0000 + 32'(c) * 32'h1000;
    endfunction
    function automatic logic [31:0] clm_a(input int c);
        return thr_a(c) + 32'd4;
    endfunction

    function automatic int exp_best(input int c);
        int bp = 0;
        int b = 0;
        for (int s = 1; s <= NSRC; s++) begin
            if (pend[s] && m_en[c][s] && !m_claimed[s] && (m_prio[s] > m_thr[c]) && (m_prio[s] > bp)) begin
                bp = m_prio[s];
                b = s;
            end
        end
        return b;
    endfunction

    // one access: request at a falling edge, ack sampled at the next one
    task automatic bus_op(input logic w, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        check("R11 ack after request", 32'(ack), 32'd1);
        last_rd = rdata;
        last_done = done;
    endtask

    task automatic rd_check(input string tag, input logic [31:0] a, input logic [31:0] exp);
        bus_op(1'b0, a, 32'd0);
        check(tag, last_rd, exp);
    endtask

    task automatic set_prio(input int s, input logic [31:0] v);
        bus_op(1'b1, prio_a(s), v);
        if (s >= 1 && s <= NSRC) m_prio[s] = int'(v & 32'd7);
    endtask

    task automatic set_en(input int c, input logic [31:0] v);
        bus_op(1'b1, en_a(c), v);
        for (int s = 1; s <= NSRC; s++) m_en[c][s] = v[s];
    endtask

    task automatic set_thr(input int c, input logic [31:0] v);
        bus_op(1'b1, thr_a(c), v);
        m_thr[c] = int'(v & 32'd7);
    endtask

    task automatic claim(input string tag, input int c);
        int e;
        e = exp_best(c);
        bus_op(1'b0, clm_a(c), 32'd0);
        check(tag, last_rd, 32'(e));
        if (e != 0) m_claimed[e] = 1'b1;
    endtask

    task automatic complete(input string tag, input int c, input int id);
        logic [NSRC:1] e;
        e = '0;
        if (id >= 1 && id <= NSRC && m_en[c][id]) begin
            e[id] = 1'b1;
            m_claimed[id] = 1'b0;
        end
        bus_op(1'b1, clm_a(c), 32'(id));
        check(tag, {last_done, 1'b0}, {e, 1'b0});
    endtask

    task automatic set_pend(input logic [NSRC:1] v);
        @(negedge clk);
        pend = v;
    endtask

    task automatic irq_check(input string tag);
        repeat (2) @(negedge clk);
        for (int c = 0; c < NCTX; c++) check(tag, 32'(irq[c]), 32'(exp_best(c) != 0));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired before the test ended");
        finish_run();
    end

    initial begin
        for (int s = 0; s < 32; s++) begin
            m_prio[s] = 0;
            m_claimed[s] = 1'b0;
            for (int c = 0; c < NCTX; c++) m_en[c][s] = 1'b0;
        end
        for (int c = 0; c < NCTX; c++) m_thr[c] = 0;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pend = '1;

        // R1 reset state
        @(negedge clk);
        check("R1 irq low after reset", 32'(irq), 32'd0);
        rd_check("R1 priority reset", prio_a(5), 32'd0);
        rd_check("R1 enable reset", en_a(1), 32'd0);
        rd_check("R1 threshold reset", thr_a(0), 32'd0);
        claim("R1 claim empty after reset", 0);

        // R2 priority width and source 0
        set_prio(3, 32'hFF);
        rd_check("R2 priority upper bits zero", prio_a(3), 32'd7);
        set_prio(0, 32'd5);
        rd_check("R2 source 0 priority stays 0", prio_a(0), 32'd0);

        // R3 enable layout, bit 0 hardwired
        set_en(1, 32'hFFFF_FFFF);
        rd_check("R3 enable bit0 reads 0", en_a(1), 32'hFFFF_FFFE);
        set_en(1, 32'd0);
        rd_check("R3 enable cleared", en_a(1), 32'd0);

        // R4 strict threshold, priority 0 masks
        set_prio(4, 32'd2);
        set_en(0, 32'h0000_0010);
        set_thr(0, 32'd2);
        claim("R4 priority equal to threshold blocked", 0);
        set_thr(0, 32'd1);
        claim("R4 priority above threshold claimed", 0);
        complete("R7 complete enabled source", 0, 4);
        set_prio(4, 32'd0);
        set_thr(0, 32'd0);
        claim("R4 priority 0 masks source", 0);

        // R5 priority order and tie break
        set_prio(5, 32'd6);
        set_prio(9, 32'd6);
        set_prio(7, 32'd3);
        set_en(0, (32'd1 << 5) | (32'd1 << 7) | (32'd1 << 9));
        claim("R5 tie goes to lower id", 0);
        claim("R5 second of tied pair", 0);
        claim("R5 lower priority last", 0);
        claim("R6 claim returns 0 when all taken", 0);
        complete("R7 complete source 5", 0, 5);
        claim("R6 reclaim after complete", 0);

        // R6 claimed source hidden from other context
        set_en(1, 32'd1 << 5);
        claim("R6 claimed source not given to other context", 1);

        // R8 completion for non-enabled source ignored
        complete("R8 complete of non-enabled source ignored", 1, 9);
        complete("R8 out of range id ignored", 0, 40);
        claim("R8 claim still held", 0);
        complete("R7 complete source 9", 0, 9);
        claim("R8 source 9 returns after real complete", 0);

        // R9 registered irq timing
        complete("R7 release 9", 0, 9);
        complete("R7 release 5", 0, 5);
        complete("R7 release 7", 0, 7);
        set_pend('0);
        irq_check("R9 irq low with nothing pending");
        @(negedge clk);
        pend[7] = 1'b1;
        #1;
        check("R9 irq not yet raised in same cycle", 32'(irq), 32'd0);
        @(negedge clk);
        check("R9 irq raised one cycle later", 32'(irq[0]), 32'd1);
        check("R9 context without enable stays low", 32'(irq[1]), 32'd0);

        // R10 unmapped space
        bus_op(1'b1, 32'h1000, 32'hFFFF_FFFF);
        rd_check("R10 unmapped read zero", 32'h1000, 32'd0);
        rd_check("R10 gap in context block", thr_a(0) + 32'd8, 32'd0);
        rd_check("R10 nonexistent context enable", en_a(2), 32'd0);
        bus_op(1'b1, thr_a(2), 32'd7);
        rd_check("R10 nonexistent context threshold", thr_a(2), 32'd0);
        bus_op(1'b1, en_a(0) + 32'd4, 32'hFFFF_FFFF);
        rd_check("R10 enable word past sources", en_a(0) + 32'd4, 32'd0);
        rd_check("R10 real threshold untouched", thr_a(0), 32'd0);

        // R11 request during ST_ACK ignored
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = ADDR_W'(prio_a(6)); wdata = 32'd5;
        @(negedge clk);
        check("R11 ack in second cycle", 32'(ack), 32'd1);
        wdata = 32'd2;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        check("R11 no ack for request in ack cycle", 32'(ack), 32'd0);
        m_prio[6] = 5;
        rd_check("R11 ignored write left priority", prio_a(6), 32'd5);

        // random mix
        for (int it = 0; it < 500; it++) begin
            int op;
            int c;
            op = int'($urandom_range(0, 7));
            c = int'($urandom_range(0, NCTX - 1));
            case (op)
                0: set_prio(int'($urandom_range(0, NSRC)), $urandom());
                1: set_en(c, $urandom());
                2: set_thr(c, 32'($urandom_range(0, 7)));
                3: set_pend(NSRC'($urandom()));
                4, 5: claim("R5 R6 random claim", c);
                6: begin
                    int id;
                    id = int'($urandom_range(0, NSRC + 2));
                    for (int s = 1; s <= NSRC; s++) if (m_claimed[s] && ($urandom_range(0, 3) == 0)) id = s;
                    complete("R7 R8 random complete", c, id);
                end
                default: begin
                    int s;
                    s = int'($urandom_range(0, NSRC));
                    rd_check("R2 random priority readback", prio_a(s), 32'(m_prio[s]));
                    irq_check("R9 random irq level");
                end
            endcase
        end

        finish_run();
    end

endmodule